// File: doc/BRIEF.md
# Processor Bus Cycle Decoder and Lock Tracker

This block sits on the system side of a 486-class processor local bus. Each time the processor pulls its address strobe low, the block captures the three cycle-definition lines, the four byte enables and address bits A4 to A2. From them it produces a one-hot cycle type and, for special cycles, flags for shutdown, halt, stop-grant or an unrecognised pattern. It also flags the reserved definition code.

The block follows each bus cycle from its address strobe to the clock in which either ready input is returned. From the lock input it keeps a lock-active flag, and while that flag is set it withholds the bus-hold acknowledge. It samples the pseudo-lock input only in ready clocks to report whether the next cycle continues the same transaction. It qualifies cache line fills at completion, and it never qualifies a locked read. A ready that arrives with no cycle open sets a sticky protocol-error bit. All outputs are registered, and reset is synchronous and active low.

Top module: `busdec_top`

## Requirements
- R1: The clock after an edge with `ads_n` low, `cyc_type` is one-hot, with the bit at index {mio,dc,wr} set. The codes are 000 interrupt acknowledge, 001 special, 010 I/O read, 011 I/O write, 100 code read, 101 reserved, 110 memory read and 111 memory write. The value holds until the next strobe.
- R2: For a special cycle (code 001), the block sets `shutdown` when `be_n`=1110 and `adr`=000, `halt` when `be_n`=1011 and `adr`=000, and `stop_grant` when `be_n`=1011 and `adr`=100. These flags update with `cyc_type` and read 0 for non-special cycles.
- R3: `unk_special` is set for a special cycle with any other byte-enable/address pair. `rsvd_cycle` is set for code 101.
- R4: `cyc_open` rises the clock after a strobe. It falls the clock after an edge where it was set and either `rdy_n` or `brdy_n` was low, unless a new strobe arrives in that same clock.
- R5: `rdy_n` or `brdy_n` low at an edge with no open cycle sets `proto_err`, which stays set until reset.
- R6: `lock_active` sets the clock after a strobe sampled with `lock_n` low. It stays set across the locked cycles. It clears after the first edge with no open cycle, no strobe and `lock_n` high.
- R7: `hold_ack` follows `hold_req` one clock later. It is forced low while `lock_active` is set and on the strobe edge of a locked cycle.
- R8: For one clock after a ready edge, `fill_ok` is high when the completing cycle is a memory read or a code read, `ken_n` was low at that edge and the cycle was not locked. Otherwise `fill_ok` is low.
- R9: `multi_cycle` loads the inverse of `plock_n` at each ready edge of an open cycle. Changes of `plock_n` at other edges leave it unchanged.
- R10: While `rst_n` is low at an edge, all outputs go to 0, including `hold_ack` when `hold_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ads_n | input | 1 | Address strobe, active low |
| mio | input | 1 | Memory (1) or I/O (0) definition line |
| dc | input | 1 | Data (1) or control (0) definition line |
| wr | input | 1 | Write (1) or read (0) definition line |
| be_n | input | 4 | Byte enables, active low |
| adr | input | 3 | Address bits A4..A2 |
| lock_n | input | 1 | Bus lock, active low |
| plock_n | input | 1 | Pseudo-lock, active low |
| rdy_n | input | 1 | Non-burst ready, active low |
| brdy_n | input | 1 | Burst ready, active low |
| ken_n | input | 1 | Cacheability, active low |
| hold_req | input | 1 | Bus-hold request from the system |
| hold_ack | output | 1 | Bus-hold acknowledge |
| cyc_type | output | 8 | One-hot cycle type |
| shutdown | output | 1 | Special cycle is a shutdown |
| halt | output | 1 | Special cycle is a halt |
| stop_grant | output | 1 | Special cycle is a stop-grant |
| unk_special | output | 1 | Special cycle with an unlisted pattern |
| rsvd_cycle | output | 1 | Reserved definition code |
| cyc_open | output | 1 | A bus cycle is in progress |
| lock_active | output | 1 | A locked sequence is in progress |
| multi_cycle | output | 1 | The last completed cycle had pseudo-lock active |
| fill_ok | output | 1 | The completed cycle qualifies as a cache fill |
| proto_err | output | 1 | Sticky: a ready arrived with no open cycle |

## Verification
The hardest case to reach is the end of a locked sequence. The flag must survive the ready of each locked cycle and the gap between cycles while `lock_n` stays low. It must then clear only after the last ready, and the hold acknowledge must come back one clock later. The bench first grants a pending hold request. It then runs two locked cycles back to back, the first a cacheable memory read. It releases `lock_n` in the clock right after the final ready and checks `lock_active` and `hold_ack` in each of the following clocks. A scoreboard queue checks the decoding of every strobe, including all special-cycle patterns.

// File: rtl/busdec_pkg.sv
// Shared constants and encodings for the bus cycle decoder.
// Assumes the 3-bit definition code is ordered {M/IO, D/C, W/R}.
package busdec_pkg;
    localparam int DEF_W     = 3;
    localparam int BE_W      = 4;
    localparam int ADR_W     = 3;
    localparam int NUM_TYPES = 1 << DEF_W;

    localparam logic [DEF_W-1:0] DEF_SPECIAL = 3'b001;
    localparam logic [DEF_W-1:0] DEF_CODERD  = 3'b100;
    localparam logic [DEF_W-1:0] DEF_RSVD    = 3'b101;
    localparam logic [DEF_W-1:0] DEF_MEMRD   = 3'b110;

    localparam logic [BE_W-1:0]  BE_SHUT     = 4'b1110;
    localparam logic [BE_W-1:0]  BE_HALTSTOP = 4'b1011;
    localparam logic [ADR_W-1:0] ADR_ZERO    = 3'b000;
    localparam logic [ADR_W-1:0] ADR_STOP    = 3'b100;

    typedef struct packed {
        logic shutdown;
        logic halt;
        logic stop_grant;
        logic unknown;
    } special_t;

    // Classifies a special cycle from byte enables and address bits.
    function automatic special_t classify_special(input logic [BE_W-1:0] be,
                                                  input logic [ADR_W-1:0] a);
        special_t s;
        s.shutdown   = (be == BE_SHUT)     && (a == ADR_ZERO);
        s.halt       = (be == BE_HALTSTOP) && (a == ADR_ZERO);
        s.stop_grant = (be == BE_HALTSTOP) && (a == ADR_STOP);
        s.unknown    = !(s.shutdown || s.halt || s.stop_grant);
        return s;
    endfunction
endpackage

// File: rtl/cycle_track.sv
// Tracks whether a bus cycle is open, from address strobe to ready.
// Assumes a strobe in the same clock as a ready starts a new cycle.
module cycle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ads_n,
    input  logic rdy_n,
    input  logic brdy_n,
    output logic cyc_open,
    output logic cyc_done,
    output logic proto_err
);
    logic any_rdy;

    assign any_rdy  = !rdy_n || !brdy_n;
    assign cyc_done = cyc_open && any_rdy;

    // Open/close the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        cyc_open <= 1'b0;
        else if (!ads_n)   cyc_open <= 1'b1;
        else if (cyc_done) cyc_open <= 1'b0;
    end

    // Sticky flag for a ready with no cycle open.
    always_ff @(posedge clk) begin
        if (!rst_n)                     proto_err <= 1'b0;
        else if (any_rdy && !cyc_open)  proto_err <= 1'b1;
    end

    assert_open_on_ads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> cyc_open);
    assert_open_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && ads_n) |=> !cyc_open);
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

// File: rtl/cycle_decode.sv
// Captures the cycle definition at the address strobe and decodes it.
// Assumes definition lines, byte enables and address are valid with the strobe.
module cycle_decode
    import busdec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ads_n,
    input  logic [DEF_W-1:0]     def_code,
    input  logic [BE_W-1:0]      be_n,
    input  logic [ADR_W-1:0]     adr,
    input  logic                 lock_n,
    input  logic                 cyc_open,
    output logic [NUM_TYPES-1:0] cyc_type,
    output special_t             spec,
    output logic                 rsvd_cycle,
    output logic                 cap_lock,
    output logic                 cap_fillable
);
    logic [NUM_TYPES-1:0] type_hit;
    special_t             spec_now;
    logic                 is_special;

    for (genvar i = 0; i < NUM_TYPES; i++) begin : g_type
        assign type_hit[i] = (def_code == DEF_W'(i));
    end

    assign is_special = (def_code == DEF_SPECIAL);
    assign spec_now   = is_special ? classify_special(be_n, adr) : '0;

    // Register the decoded cycle at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_type     <= '0;
            spec         <= '0;
            rsvd_cycle   <= 1'b0;
            cap_lock     <= 1'b0;
            cap_fillable <= 1'b0;
        end else if (!ads_n) begin
            cyc_type     <= type_hit;
            spec         <= spec_now;
            rsvd_cycle   <= (def_code == DEF_RSVD);
            cap_lock     <= !lock_n;
            cap_fillable <= (def_code == DEF_MEMRD) || (def_code == DEF_CODERD);
        end
    end

    assert_type_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_open |-> ($countones(cyc_type) == 1));
    assert_special_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(spec) <= 1);
    assert_special_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (spec != '0) |-> cyc_type[DEF_SPECIAL]);
endmodule

// File: rtl/lock_track.sv
// Lock and pseudo-lock tracking, hold gating and fill qualification.
// Assumes lock_n stays low between the cycles of a locked sequence.
module lock_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ads_n,
    input  logic lock_n,
    input  logic plock_n,
    input  logic ken_n,
    input  logic hold_req,
    input  logic cyc_open,
    input  logic cyc_done,
    input  logic cap_lock,
    input  logic cap_fillable,
    output logic lock_active,
    output logic hold_ack,
    output logic multi_cycle,
    output logic fill_ok
);
    logic lock_start;
    logic lock_end;

    assign lock_start = !ads_n && !lock_n;
    assign lock_end   = lock_active && !cyc_open && ads_n && lock_n;

    // Lock-active flag spanning the locked sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)          lock_active <= 1'b0;
        else if (lock_start) lock_active <= 1'b1;
        else if (lock_end)   lock_active <= 1'b0;
    end

    // Hold acknowledge, withheld during a lock.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_ack <= 1'b0;
        else        hold_ack <= hold_req && !lock_active && !lock_start;
    end

    // Pseudo-lock sampled only at ready.
    always_ff @(posedge clk) begin
        if (!rst_n)        multi_cycle <= 1'b0;
        else if (cyc_done) multi_cycle <= !plock_n;
    end

    // One-clock cache-fill qualification at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) fill_ok <= 1'b0;
        else        fill_ok <= cyc_done && cap_fillable && !cap_lock && !ken_n;
    end

    assert_no_hold_in_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |-> !hold_ack);
    assert_fill_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok |-> ($past(cyc_done) && !$past(cap_lock)));
    assert_multi_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_done |=> $stable(multi_cycle));
    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_active && cyc_open) |=> lock_active);
endmodule

// File: rtl/busdec_top.sv
// Top level: bus cycle decoder with lock and pseudo-lock tracking.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module busdec_top
    import busdec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ads_n,
    input  logic                 mio,
    input  logic                 dc,
    input  logic                 wr,
    input  logic [BE_W-1:0]      be_n,
    input  logic [ADR_W-1:0]     adr,
    input  logic                 lock_n,
    input  logic                 plock_n,
    input  logic                 rdy_n,
    input  logic                 brdy_n,
    input  logic                 ken_n,
    input  logic                 hold_req,
    output logic                 hold_ack,
    output logic [NUM_TYPES-1:0] cyc_type,
    output logic                 shutdown,
    output logic                 halt,
    output logic                 stop_grant,
    output logic                 unk_special,
    output logic                 rsvd_cycle,
    output logic                 cyc_open,
    output logic                 lock_active,
    output logic                 multi_cycle,
    output logic                 fill_ok,
    output logic                 proto_err
);
    logic     cyc_done;
    logic     cap_lock;
    logic     cap_fillable;
    special_t spec;

    cycle_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ads_n     (ads_n),
        .rdy_n     (rdy_n),
        .brdy_n    (brdy_n),
        .cyc_open  (cyc_open),
        .cyc_done  (cyc_done),
        .proto_err (proto_err)
    );

    cycle_decode u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .ads_n        (ads_n),
        .def_code     ({mio, dc, wr}),
        .be_n         (be_n),
        .adr          (adr),
        .lock_n       (lock_n),
        .cyc_open     (cyc_open),
        .cyc_type     (cyc_type),
        .spec         (spec),
        .rsvd_cycle   (rsvd_cycle),
        .cap_lock     (cap_lock),
        .cap_fillable (cap_fillable)
    );

    lock_track u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .ads_n        (ads_n),
        .lock_n       (lock_n),
        .plock_n      (plock_n),
        .ken_n        (ken_n),
        .hold_req     (hold_req),
        .cyc_open     (cyc_open),
        .cyc_done     (cyc_done),
        .cap_lock     (cap_lock),
        .cap_fillable (cap_fillable),
        .lock_active  (lock_active),
        .hold_ack     (hold_ack),
        .multi_cycle  (multi_cycle),
        .fill_ok      (fill_ok)
    );

    assign shutdown    = spec.shutdown;
    assign halt        = spec.halt;
    assign stop_grant  = spec.stop_grant;
    assign unk_special = spec.unknown;
endmodule

// File: tb/busdec_top_tb.sv
module busdec_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ads_n = 1'b1, mio = 1'b0, dc = 1'b0, wr = 1'b0;
    logic [3:0] be_n = 4'hF;
    logic [2:0] adr = 3'b000;
    logic lock_n = 1'b1, plock_n = 1'b1, rdy_n = 1'b1, brdy_n = 1'b1, ken_n = 1'b1;
    logic hold_req = 1'b0;
    logic hold_ack, shutdown, halt, stop_grant, unk_special, rsvd_cycle;
    logic cyc_open, lock_active, multi_cycle, fill_ok, proto_err;
    logic [7:0] cyc_type;

    int checks = 0;
    int errors = 0;
    logic ads_d = 1'b0;

    typedef struct packed {
        logic [7:0] ty;
        logic sd, hl, sg, uk, rs;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    busdec_top u_dut (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mio(mio), .dc(dc), .wr(wr),
        .be_n(be_n), .adr(adr), .lock_n(lock_n), .plock_n(plock_n),
        .rdy_n(rdy_n), .brdy_n(brdy_n), .ken_n(ken_n), .hold_req(hold_req),
        .hold_ack(hold_ack), .cyc_type(cyc_type), .shutdown(shutdown),
        .halt(halt), .stop_grant(stop_grant), .unk_special(unk_special),
        .rsvd_cycle(rsvd_cycle), .cyc_open(cyc_open), .lock_active(lock_active),
        .multi_cycle(multi_cycle), .fill_ok(fill_ok), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected decode per R1, R2, R3.
    function automatic exp_t expect_of(input logic [2:0] d, input logic [3:0] be,
                                       input logic [2:0] a);
        exp_t e;
        e = '0;
        e.ty = 8'(1) << d;
        if (d == 3'b001) begin
            e.sd = (be == 4'b1110) && (a == 3'b000);
            e.hl = (be == 4'b1011) && (a == 3'b000);
            e.sg = (be == 4'b1011) && (a == 3'b100);
            e.uk = !(e.sd || e.hl || e.sg);
        end
        e.rs = (d == 3'b101);
        return e;
    endfunction

    // Driver: strobe one cycle and push its expectation. Called at a negedge.
    task automatic strobe(input logic [2:0] d, input logic [3:0] be, input logic [2:0] a);
        {mio, dc, wr} = d;
        be_n = be;
        adr = a;
        ads_n = 1'b0;
        sb_q.push_back(expect_of(d, be, a));
        @(negedge clk);
        ads_n = 1'b1;
    endtask

    // Driver: one ready clock. Called at a negedge.
    task automatic ready(input logic burst, input logic pl, input logic kn);
        if (burst) brdy_n = 1'b0; else rdy_n = 1'b0;
        plock_n = pl;
        ken_n = kn;
        @(negedge clk);
        rdy_n = 1'b1;
        brdy_n = 1'b1;
        plock_n = 1'b1;
        ken_n = 1'b1;
    endtask

    always @(posedge clk) ads_d <= rst_n && !ads_n;

    // Monitor: compare decode outputs after every strobe.
    always @(negedge clk) begin
        if (ads_d) begin
            exp_t e;
            if (sb_q.size() == 0) begin
                chk("R1 scoreboard underflow", 1, 0);
            end else begin
                e = sb_q.pop_front();
                chk("R1 cyc_type", cyc_type, e.ty);
                chk("R2 shutdown", shutdown, e.sd);
                chk("R2 halt", halt, e.hl);
                chk("R2 stop_grant", stop_grant, e.sg);
                chk("R3 unk_special", unk_special, e.uk);
                chk("R3 rsvd_cycle", rsvd_cycle, e.rs);
                chk("R4 cyc_open after strobe", cyc_open, 1);
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        hold_req = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 hold_ack in reset", hold_ack, 0);
        chk("R10 outputs in reset", {cyc_type, shutdown, halt, stop_grant, unk_special,
            rsvd_cycle, cyc_open, lock_active, multi_cycle, fill_ok, proto_err}, 0);
        rst_n = 1'b1;
        hold_req = 1'b0;
        @(negedge clk);

        // R8: cacheable unlocked memory read qualifies as a fill
        strobe(3'b110, 4'b0000, 3'b000);
        ready(1'b0, 1'b1, 1'b0);
        chk("R8 fill_ok after memory read", fill_ok, 1);
        chk("R4 cyc_open cleared by rdy", cyc_open, 0);
        chk("R9 multi_cycle plock inactive", multi_cycle, 0);
        @(negedge clk);
        chk("R8 fill_ok one clock", fill_ok, 0);

        // R4: code read closed by burst ready, not cacheable
        strobe(3'b100, 4'b0000, 3'b000);
        @(negedge clk);
        chk("R4 cyc_open held while waiting", cyc_open, 1);
        ready(1'b1, 1'b1, 1'b1);
        chk("R4 cyc_open cleared by brdy", cyc_open, 0);
        chk("R8 no fill without ken", fill_ok, 0);

        // R9: pseudo-lock sampling
        strobe(3'b010, 4'b1100, 3'b001);
        ready(1'b0, 1'b0, 1'b1);
        chk("R9 multi_cycle set at ready", multi_cycle, 1);
        plock_n = 1'b1;
        @(negedge clk);
        plock_n = 1'b0;
        @(negedge clk);
        plock_n = 1'b1;
        chk("R9 multi_cycle unchanged off ready", multi_cycle, 1);
        strobe(3'b011, 4'b1100, 3'b001);
        ready(1'b0, 1'b1, 1'b1);
        chk("R9 multi_cycle cleared at ready", multi_cycle, 0);

        // R2, R3: special and other codes
        strobe(3'b001, 4'b1110, 3'b000); ready(1'b0, 1'b1, 1'b1);
        strobe(3'b001, 4'b1011, 3'b000); ready(1'b0, 1'b1, 1'b1);
        strobe(3'b001, 4'b1011, 3'b100); ready(1'b0, 1'b1, 1'b1);
        strobe(3'b001, 4'b1111, 3'b000); ready(1'b0, 1'b1, 1'b1);
        strobe(3'b001, 4'b1110, 3'b100); ready(1'b0, 1'b1, 1'b1);
        strobe(3'b101, 4'b0000, 3'b000); ready(1'b0, 1'b1, 1'b1);
        strobe(3'b000, 4'b1110, 3'b000); ready(1'b0, 1'b1, 1'b1);
        strobe(3'b111, 4'b0000, 3'b000);
        strobe(3'b110, 4'b1011, 3'b000);
        ready(1'b0, 1'b1, 1'b1);

        // R7: hold granted when not locked
        hold_req = 1'b1;
        @(negedge clk);
        chk("R7 hold_ack follows request", hold_ack, 1);

        // R6, R7, R8: locked sequence of two cycles
        lock_n = 1'b0;
        strobe(3'b110, 4'b0000, 3'b000);
        chk("R6 lock_active after locked strobe", lock_active, 1);
        chk("R7 hold_ack withheld on lock", hold_ack, 0);
        ready(1'b0, 1'b1, 1'b0);
        chk("R8 locked read not a fill", fill_ok, 0);
        @(negedge clk);
        chk("R6 lock held between locked cycles", lock_active, 1);
        strobe(3'b111, 4'b0000, 3'b000);
        rdy_n = 1'b0;
        @(negedge clk);
        rdy_n = 1'b1;
        lock_n = 1'b1;
        chk("R6 lock held after last ready edge", lock_active, 1);
        chk("R7 hold_ack withheld in lock", hold_ack, 0);
        @(negedge clk);
        chk("R6 lock_active cleared", lock_active, 0);
        chk("R7 hold_ack still low", hold_ack, 0);
        @(negedge clk);
        chk("R7 hold_ack returns after lock", hold_ack, 1);
        hold_req = 1'b0;
        @(negedge clk);
        chk("R7 hold_ack drops with request", hold_ack, 0);

        // R5: stray ready
        chk("R5 proto_err clear before stray", proto_err, 0);
        ready(1'b0, 1'b1, 1'b1);
        chk("R5 proto_err on stray ready", proto_err, 1);
        repeat (3) @(negedge clk);
        chk("R5 proto_err sticky", proto_err, 1);
        chk("R1 scoreboard drained", sb_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule